// File: doc/BRIEF.md
# Clock Correction Phase Scheduler

This block decides when a time-triggered bus node launches its clock-correction calculations and when their results take effect. It follows a three-valued mode command and a startup command, and it watches the cycle parity and the segment markers of each communication cycle. It issues start strobes to an external correction unit, which answers with a done pulse after a variable latency. An offset calculation is launched in every cycle. A rate calculation is launched only in odd cycles, so it runs once per even/odd cycle pair.

Results may come back early, during the dynamic segment or the symbol window. The block holds them and publishes them only on a clock edge at which the network idle time marker is high. The published values are the sync-result code, the corrected microticks-per-cycle value and one-cycle ready pulses.

Each calculation has a deadline:
- The offset calculation must finish before the offset-correction phase starts.
- The rate calculation must finish before the next even cycle begins.

A missed deadline drops that calculation and sets a sticky error.

Top module: `ccs_sched`

## Requirements
- R1: After reset the block is idle. No strobe or ready pulse is high, the sync-result output is 0, the error output is 0, and the microticks-per-cycle output equals the configured nominal value (default 1000).
- R2: A mode value of 0 (standby) or 3 (reserved, treated as standby) returns the block to idle on the next edge. It clears all start strobes, outstanding calculations, pending results and ready pulses. A done pulse that arrives while in standby has no visible effect.
- R3: After leaving standby, no start strobe is issued until a coldstart or integrate command pulse has been seen.
- R4: While running, a static-end pulse produces an offset start strobe on the next edge. When the cycle parity input (LSB of the cycle counter, 0 = even) is 1 at that pulse, the same edge also produces a rate start strobe.
- R5: The own-clock-include output is high exactly while the block is running and the mode is 2 (sync). With mode 1 (nosync) it stays low.
- R6: A done pulse is accepted only while its calculation is outstanding. At acceptance the result is captured. A done pulse with nothing outstanding is ignored.
- R7: A captured sync-result code (0 within bounds, 1 exceeds bounds, 2 missing term) appears on the first later edge with network idle time high. The offset ready output pulses high for that one cycle.
- R8: A captured signed rate correction is added to the nominal microticks-per-cycle. The sum appears on the first later edge with network idle time high, and the rate ready output pulses for that cycle.
- R9: An offset-phase-start pulse while the offset calculation is outstanding, without a done pulse in the same cycle, drops that calculation. No offset ready follows, and a miss is recorded.
- R10: A cycle parity change from 1 to 0 while the rate calculation is outstanding, without a done pulse in the same cycle, drops that calculation. A miss is recorded and the previous corrected cycle length is kept.
- R11: The error output takes the recorded miss state only on edges with network idle time high. Once set, only reset clears it.
- R12: The sync-result and microticks-per-cycle outputs change only on edges at which network idle time is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | 0 standby, 1 nosync, 2 sync, 3 treated as standby |
| cold_i | input | 1 | Coldstart command pulse |
| integ_i | input | 1 | Integrate command pulse |
| cyc_par_i | input | 1 | Cycle counter LSB, 0 = even |
| static_end_i | input | 1 | Pulse at the end of the static segment |
| nit_i | input | 1 | High during network idle time |
| ofs_phase_i | input | 1 | Pulse at the start of the offset-correction phase |
| ofs_done_i | input | 1 | Offset calculation finished |
| ofs_res_i | input | 2 | Sync-result code returned with the offset done pulse |
| rate_done_i | input | 1 | Rate calculation finished |
| rate_val_i | input | RW | Signed rate correction in microticks |
| ofs_start_o | output | 1 | Offset calculation start strobe |
| rate_start_o | output | 1 | Rate calculation start strobe |
| own_incl_o | output | 1 | Include own clock in correction terms |
| sync_res_o | output | 2 | Published sync-result code |
| ofs_rdy_o | output | 1 | Offset result published pulse |
| rate_rdy_o | output | 1 | Rate result published pulse |
| micro_cyc_o | output | MW | Corrected microticks per cycle |
| dline_err_o | output | 1 | Sticky deadline miss flag |

## Verification
The bench targets four corner cases:
- A result that returns long before network idle time. A design that forwards it at once would move the sync-result or cycle-length outputs outside the idle window.
- A negative rate correction. A design that mishandles the sign would publish a cycle length far from 975.
- Deadline expiries, both the offset phase arriving first and the parity dropping to even first, each followed by a late done pulse. A design that kept the calculation alive would accept the late result and raise a ready pulse.
- Standby in the middle of a calculation, and done pulses with nothing outstanding. A design that leaked state here would publish a stale code or miss the wait-for-startup gate.

// File: rtl/ccs_pkg.sv
package ccs_pkg;

    typedef enum logic [1:0] {
        CSM_STANDBY = 2'd0,
        CSM_NOSYNC  = 2'd1,
        CSM_SYNC    = 2'd2,
        CSM_RSVD    = 2'd3
    } csm_mode_e;

    typedef enum logic [1:0] {
        SR_WITHIN  = 2'd0,
        SR_EXCEEDS = 2'd1,
        SR_MISSING = 2'd2
    } sync_res_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_RUN  = 2'd2
    } phase_e;

    function automatic logic is_standby(input logic [1:0] m);
        return (m == CSM_STANDBY) || (m == CSM_RSVD);
    endfunction

    function automatic logic is_even_start(input logic prev_par, input logic cur_par);
        return prev_par && !cur_par;
    endfunction

endpackage

// File: rtl/ccs_mode_fsm.sv
module ccs_mode_fsm
    import ccs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_i,
    input  logic       cold_i,
    input  logic       integ_i,
    output logic       run_o,
    output logic       stby_o,
    output logic       own_incl_o
);

    phase_e phase_q;

    assign stby_o = is_standby(mode_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
        end else if (stby_o) begin
            phase_q <= PH_IDLE;
        end else begin
            case (phase_q)
                PH_IDLE: phase_q <= PH_WAIT;
                PH_WAIT: if (cold_i || integ_i) phase_q <= PH_RUN;
                PH_RUN:  phase_q <= PH_RUN;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign run_o      = (phase_q == PH_RUN);
    assign own_incl_o = run_o && (mode_i == CSM_SYNC);

endmodule

// File: rtl/ccs_calc_track.sv
module ccs_calc_track #(
    parameter int DW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush_i,
    input  logic          arm_i,
    input  logic          done_i,
    input  logic          dline_i,
    input  logic          rel_i,
    input  logic [DW-1:0] data_i,
    output logic          start_o,
    output logic          busy_o,
    output logic          pend_o,
    output logic          miss_o,
    output logic [DW-1:0] stash_o
);

    logic accept;

    assign accept = busy_o && done_i;
    assign miss_o = busy_o && dline_i && !done_i && !flush_i;

    always_ff @(posedge clk) begin
        if (rst || flush_i) begin
            start_o <= 1'b0;
            busy_o  <= 1'b0;
            pend_o  <= 1'b0;
        end else begin
            start_o <= arm_i;
            if (arm_i) begin
                busy_o <= 1'b1;
            end else if (busy_o && (done_i || dline_i)) begin
                busy_o <= 1'b0;
            end
            if (accept) begin
                pend_o <= 1'b1;
            end else if (rel_i) begin
                pend_o <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stash_o <= '0;
        end else if (accept && !flush_i) begin
            stash_o <= data_i;
        end
    end

endmodule

// File: rtl/ccs_release.sv
module ccs_release #(
    parameter int MW  = 16,
    parameter int RW  = 12,
    parameter int NOM = 1000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          nit_i,
    input  logic          stby_i,
    input  logic          opend_i,
    input  logic [1:0]    ostash_i,
    input  logic          rpend_i,
    input  logic [RW-1:0] rstash_i,
    input  logic          omiss_i,
    input  logic          rmiss_i,
    output logic          orel_o,
    output logic          rrel_o,
    output logic [1:0]    sync_res_o,
    output logic          ofs_rdy_o,
    output logic          rate_rdy_o,
    output logic [MW-1:0] micro_o,
    output logic          err_o
);

    localparam logic [MW-1:0] NOM_W = MW'(NOM);
    localparam int            XW    = MW + 1 - RW;

    logic              miss_q;
    logic signed [MW:0] sum;

    assign orel_o = nit_i && !stby_i && opend_i;
    assign rrel_o = nit_i && !stby_i && rpend_i;
    assign sum    = $signed({1'b0, NOM_W}) + $signed({{XW{rstash_i[RW-1]}}, rstash_i});

    always_ff @(posedge clk) begin
        if (rst) begin
            miss_q     <= 1'b0;
            err_o      <= 1'b0;
            ofs_rdy_o  <= 1'b0;
            rate_rdy_o <= 1'b0;
            sync_res_o <= 2'd0;
            micro_o    <= NOM_W;
        end else begin
            miss_q     <= miss_q | omiss_i | rmiss_i;
            ofs_rdy_o  <= orel_o;
            rate_rdy_o <= rrel_o;
            if (nit_i)  err_o      <= miss_q;
            if (orel_o) sync_res_o <= ostash_i;
            if (rrel_o) micro_o    <= sum[MW-1:0];
        end
    end

endmodule

// File: rtl/ccs_sched.sv
module ccs_sched
    import ccs_pkg::*;
#(
    parameter int MW  = 16,
    parameter int RW  = 12,
    parameter int NOM = 1000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    mode_i,
    input  logic          cold_i,
    input  logic          integ_i,
    input  logic          cyc_par_i,
    input  logic          static_end_i,
    input  logic          nit_i,
    input  logic          ofs_phase_i,
    input  logic          ofs_done_i,
    input  logic [1:0]    ofs_res_i,
    input  logic          rate_done_i,
    input  logic [RW-1:0] rate_val_i,
    output logic          ofs_start_o,
    output logic          rate_start_o,
    output logic          own_incl_o,
    output logic [1:0]    sync_res_o,
    output logic          ofs_rdy_o,
    output logic          rate_rdy_o,
    output logic [MW-1:0] micro_cyc_o,
    output logic          dline_err_o
);

    logic          run, stby, par_q, even_start;
    logic          arm_ofs, arm_rate;
    logic          o_busy, o_pend, o_miss, o_rel;
    logic          r_busy, r_pend, r_miss, r_rel;
    logic [1:0]    o_stash;
    logic [RW-1:0] r_stash;

    ccs_mode_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .mode_i     (mode_i),
        .cold_i     (cold_i),
        .integ_i    (integ_i),
        .run_o      (run),
        .stby_o     (stby),
        .own_incl_o (own_incl_o)
    );

    always_ff @(posedge clk) begin
        if (rst) par_q <= 1'b0;
        else     par_q <= cyc_par_i;
    end

    assign even_start = is_even_start(par_q, cyc_par_i);
    assign arm_ofs    = run && static_end_i && !stby;
    assign arm_rate   = arm_ofs && cyc_par_i;

    ccs_calc_track #(.DW(2)) u_ofs (
        .clk     (clk),
        .rst     (rst),
        .flush_i (stby),
        .arm_i   (arm_ofs),
        .done_i  (ofs_done_i),
        .dline_i (ofs_phase_i),
        .rel_i   (o_rel),
        .data_i  (ofs_res_i),
        .start_o (ofs_start_o),
        .busy_o  (o_busy),
        .pend_o  (o_pend),
        .miss_o  (o_miss),
        .stash_o (o_stash)
    );

    ccs_calc_track #(.DW(RW)) u_rate (
        .clk     (clk),
        .rst     (rst),
        .flush_i (stby),
        .arm_i   (arm_rate),
        .done_i  (rate_done_i),
        .dline_i (even_start),
        .rel_i   (r_rel),
        .data_i  (rate_val_i),
        .start_o (rate_start_o),
        .busy_o  (r_busy),
        .pend_o  (r_pend),
        .miss_o  (r_miss),
        .stash_o (r_stash)
    );

    ccs_release #(.MW(MW), .RW(RW), .NOM(NOM)) u_rel (
        .clk        (clk),
        .rst        (rst),
        .nit_i      (nit_i),
        .stby_i     (stby),
        .opend_i    (o_pend),
        .ostash_i   (o_stash),
        .rpend_i    (r_pend),
        .rstash_i   (r_stash),
        .omiss_i    (o_miss),
        .rmiss_i    (r_miss),
        .orel_o     (o_rel),
        .rrel_o     (r_rel),
        .sync_res_o (sync_res_o),
        .ofs_rdy_o  (ofs_rdy_o),
        .rate_rdy_o (rate_rdy_o),
        .micro_o    (micro_cyc_o),
        .err_o      (dline_err_o)
    );

endmodule

// File: rtl/ccs_sched_chk.sv
module ccs_sched_chk #(
    parameter int MW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    mode_i,
    input logic          nit_i,
    input logic          ofs_start_o,
    input logic          rate_start_o,
    input logic          ofs_rdy_o,
    input logic          rate_rdy_o,
    input logic [1:0]    sync_res_o,
    input logic [MW-1:0] micro_cyc_o,
    input logic          dline_err_o
);

    AST_STBY_QUIET: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'd0 || mode_i == 2'd3) |=> (!ofs_start_o && !rate_start_o && !ofs_rdy_o && !rate_rdy_o)); // R2

    AST_RATE_WITH_OFS: assert property (@(posedge clk) disable iff (rst)
        rate_start_o |-> ofs_start_o); // R4

    AST_OFS_RDY_AT_NIT: assert property (@(posedge clk) disable iff (rst)
        ofs_rdy_o |-> $past(nit_i)); // R7

    AST_RATE_RDY_AT_NIT: assert property (@(posedge clk) disable iff (rst)
        rate_rdy_o |-> $past(nit_i)); // R8

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        $past(dline_err_o) |-> dline_err_o); // R11

    AST_ERR_AT_NIT: assert property (@(posedge clk) disable iff (rst)
        !$past(nit_i) |-> $stable(dline_err_o)); // R11

    AST_RES_HELD: assert property (@(posedge clk) disable iff (rst)
        !$past(nit_i) |-> $stable(sync_res_o)); // R12

    AST_MICRO_HELD: assert property (@(posedge clk) disable iff (rst)
        !$past(nit_i) |-> $stable(micro_cyc_o)); // R12

endmodule

bind ccs_sched ccs_sched_chk #(.MW(MW)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .mode_i       (mode_i),
    .nit_i        (nit_i),
    .ofs_start_o  (ofs_start_o),
    .rate_start_o (rate_start_o),
    .ofs_rdy_o    (ofs_rdy_o),
    .rate_rdy_o   (rate_rdy_o),
    .sync_res_o   (sync_res_o),
    .micro_cyc_o  (micro_cyc_o),
    .dline_err_o  (dline_err_o)
);

// File: tb/ccs_sched_tb_top.sv
module ccs_sched_tb_top;

    localparam int CLK_P = 10;
    localparam int MW    = 16;
    localparam int RW    = 12;
    localparam int NOM   = 1000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    mode = 2'd0;
    logic          cold = 0, integ = 0, cyc_par = 0, static_end = 0, nit = 0;
    logic          ofs_phase = 0, ofs_done = 0, rate_done = 0;
    logic [1:0]    ofs_res = 2'd0;
    logic [RW-1:0] rate_val = '0;
    logic          ofs_start, rate_start, own_incl, ofs_rdy, rate_rdy, dline_err;
    logic [1:0]    sync_res;
    logic [MW-1:0] micro_cyc;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 0;

    always #(CLK_P/2) clk = ~clk;

    ccs_sched #(.MW(MW), .RW(RW), .NOM(NOM)) dut_i (
        .clk(clk), .rst(rst), .mode_i(mode), .cold_i(cold), .integ_i(integ),
        .cyc_par_i(cyc_par), .static_end_i(static_end), .nit_i(nit),
        .ofs_phase_i(ofs_phase), .ofs_done_i(ofs_done), .ofs_res_i(ofs_res),
        .rate_done_i(rate_done), .rate_val_i(rate_val),
        .ofs_start_o(ofs_start), .rate_start_o(rate_start), .own_incl_o(own_incl),
        .sync_res_o(sync_res), .ofs_rdy_o(ofs_rdy), .rate_rdy_o(rate_rdy),
        .micro_cyc_o(micro_cyc), .dline_err_o(dline_err)
    );

    // Behavioural reference model
    int m_st;             // 0 idle, 1 waiting, 2 running
    bit m_ob, m_rb, m_op, m_rp, m_os, m_rs, m_ordy, m_rrdy, m_miss, m_err, m_par;
    int m_ost, m_rsv, m_res, m_micro;
    bit sb, orl, rrl, evs, om, rm, arm;

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_ob = 0; m_rb = 0; m_op = 0; m_rp = 0; m_os = 0; m_rs = 0;
            m_ordy = 0; m_rrdy = 0; m_miss = 0; m_err = 0; m_par = 0;
            m_ost = 0; m_rsv = 0; m_res = 0; m_micro = NOM;
        end else begin
            sb  = (mode == 2'd0) || (mode == 2'd3);
            evs = m_par && !cyc_par;
            orl = nit && !sb && m_op;
            rrl = nit && !sb && m_rp;
            arm = (m_st == 2) && static_end && !sb;
            om  = !sb && m_ob && ofs_phase && !ofs_done;
            rm  = !sb && m_rb && evs && !rate_done;
            if (nit) m_err = m_miss;
            m_miss = m_miss | om | rm;
            m_ordy = orl;
            m_rrdy = rrl;
            if (orl) m_res = m_ost;
            if (rrl) m_micro = (NOM + m_rsv) & 16'hFFFF;
            if (sb) begin
                m_ob = 0; m_rb = 0; m_op = 0; m_rp = 0; m_os = 0; m_rs = 0;
                m_st = 0;
            end else begin
                if (m_ob && ofs_done) begin m_op = 1; m_ost = ofs_res; end
                else if (orl) m_op = 0;
                if (arm) m_ob = 1; else if (m_ob && (ofs_done || ofs_phase)) m_ob = 0;
                if (m_rb && rate_done) begin m_rp = 1; m_rsv = $signed(rate_val); end
                else if (rrl) m_rp = 0;
                if (arm && cyc_par) m_rb = 1; else if (m_rb && (rate_done || evs)) m_rb = 0;
                m_os = arm;
                m_rs = arm && cyc_par;
                if (m_st == 0) m_st = 1;
                else if (m_st == 1 && (cold || integ)) m_st = 2;
            end
            m_par = cyc_par;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done_flag) begin
            chk("R4 model ofs_start", ofs_start, m_os);
            chk("R4 model rate_start", rate_start, m_rs);
            chk("R5 model own_incl", own_incl, (m_st == 2 && mode == 2'd2));
            chk("R7 model sync_res", sync_res, m_res);
            chk("R7 model ofs_rdy", ofs_rdy, m_ordy);
            chk("R8 model rate_rdy", rate_rdy, m_rrdy);
            chk("R8 model micro", micro_cyc, m_micro);
            chk("R11 model err", dline_err, m_err);
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic finish_run();
        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_P * 200000);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        tick(3);
        rst = 0;
        tick(1);
        chk("R1 micro", micro_cyc, NOM);
        chk("R1 sync_res", sync_res, 0);
        chk("R1 err", dline_err, 0);
        chk("R1 ofs_start", ofs_start, 0);

        // R3: wait-for-startup gate
        mode = 2'd1; tick(2);
        static_end = 1; tick(1); static_end = 0;
        chk("R3 no strobe before startup", ofs_start, 0);
        cold = 1; tick(1); cold = 0;

        // R4/R5/R7: even cycle offset only
        cyc_par = 0;
        static_end = 1; tick(1); static_end = 0;
        chk("R4 even ofs_start", ofs_start, 1);
        chk("R4 even no rate_start", rate_start, 0);
        chk("R5 nosync own_incl", own_incl, 0);
        tick(1);
        ofs_res = 2'd1; ofs_done = 1; tick(1); ofs_done = 0;
        tick(1);
        chk("R12 result held before idle time", sync_res, 0);
        nit = 1; tick(1);
        chk("R7 sync_res released", sync_res, 1);
        chk("R7 ofs_rdy pulse", ofs_rdy, 1);
        nit = 0; tick(1);
        chk("R7 ofs_rdy single", ofs_rdy, 0);

        // R8: odd cycle, negative rate
        cyc_par = 1; tick(1);
        static_end = 1; tick(1); static_end = 0;
        chk("R4 odd rate_start", rate_start, 1);
        rate_val = -12'sd25; ofs_res = 2'd0;
        rate_done = 1; ofs_done = 1; tick(1); rate_done = 0; ofs_done = 0;
        tick(1);
        chk("R12 micro held", micro_cyc, NOM);
        nit = 1; tick(1);
        chk("R8 micro corrected", micro_cyc, NOM - 25);
        chk("R8 rate_rdy", rate_rdy, 1);
        nit = 0; tick(1);

        // R6: done with nothing outstanding
        ofs_res = 2'd2; ofs_done = 1; tick(1); ofs_done = 0;
        nit = 1; tick(1);
        chk("R6 stray done ignored res", sync_res, 0);
        chk("R6 stray done no rdy", ofs_rdy, 0);
        nit = 0; tick(1);

        // R9: offset deadline
        cyc_par = 0; tick(1);
        static_end = 1; tick(1); static_end = 0;
        tick(2);
        ofs_phase = 1; tick(1); ofs_phase = 0;
        ofs_res = 2'd1; ofs_done = 1; tick(1); ofs_done = 0;
        nit = 1; tick(1);
        chk("R9 late offset no rdy", ofs_rdy, 0);
        chk("R9 late offset res kept", sync_res, 0);
        chk("R9 miss flagged", dline_err, 1);
        nit = 0; tick(1);

        // R10: rate deadline
        cyc_par = 1; tick(1);
        static_end = 1; tick(1); static_end = 0;
        tick(1);
        cyc_par = 0; tick(2);
        rate_val = 12'sd50; rate_done = 1; tick(1); rate_done = 0;
        nit = 1; tick(1);
        chk("R10 micro retained", micro_cyc, NOM - 25);
        chk("R10 no rate_rdy", rate_rdy, 0);
        nit = 0; tick(1);

        // R5: sync mode
        mode = 2'd2; tick(1);
        chk("R5 sync own_incl", own_incl, 1);

        // R2: standby mid-calculation
        cyc_par = 1;
        static_end = 1; tick(1); static_end = 0;
        mode = 2'd0; tick(1);
        chk("R2 strobes cleared", ofs_start, 0);
        chk("R2 own_incl off", own_incl, 0);
        mode = 2'd3; tick(1);
        ofs_res = 2'd2; ofs_done = 1; tick(1); ofs_done = 0;
        nit = 1; tick(1);
        chk("R2 no rdy in standby", ofs_rdy, 0);
        chk("R2 result unchanged", sync_res, 0);
        chk("R11 err sticky", dline_err, 1);
        nit = 0;

        // Restart via integrate, missing-term code
        mode = 2'd2; cyc_par = 0; tick(2);
        static_end = 1; tick(1); static_end = 0;
        chk("R3 still waiting", ofs_start, 0);
        integ = 1; tick(1); integ = 0;
        static_end = 1; tick(1); static_end = 0;
        chk("R4 start after integrate", ofs_start, 1);
        ofs_res = 2'd2; ofs_done = 1; tick(1); ofs_done = 0;
        nit = 1; tick(1);
        chk("R7 missing term code", sync_res, 2);
        chk("R11 err kept", dline_err, 1);
        nit = 0; tick(3);
        finish_run();
    end

endmodule